// File: doc/BRIEF.md
# Interrupt CPU Interface Controller

This block sits between an interrupt selector and one processor core. Each cycle the selector presents its single best pending interrupt: a valid flag, an ID, an 8-bit priority and a Non-secure flag. The block decides whether that candidate is urgent enough to interrupt the core. The decision takes into account a priority mask, the enable bits for each security state, and the running priority. The running priority comes from a small stack holding the priorities of interrupts that have been acknowledged but not yet completed. The result drives one of two active-low request lines. One line is the normal request line, `irq_n`. The other, `fiq_n`, is a fast request line that only Secure interrupts may use.

Software reaches the block through a plain strobe-based register port. Each access carries a Secure/Non-secure attribute in `reg_ns`. Register word addresses: 0 control, 1 priority mask, 2 Secure binary point, 3 Non-secure binary point, 4 acknowledge (read), 5 end of interrupt (write), 6 running priority (read), 7 current candidate ID (read, 1023 when there is none). Reads return data combinationally in the same cycle as the strobe. The side effects of a read or write take place at the clock edge that ends the strobe cycle.

An acknowledge read either returns the candidate's ID and makes it active, or returns a spurious code: 1022 or 1023. An end-of-interrupt write retires the most recent active priority. Both events are reported to the selector as one-cycle pulses. Only 64 priority levels exist, so the low two bits of every priority and of the mask are ignored.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, `irq_n` and `fiq_n` are 1, the running priority (address 6) reads 0xFF, and with no valid candidate an acknowledge read (address 4) returns 1023 and produces no `ack_vld` pulse.
- R2: A candidate is signalled only if its priority is strictly below the mask (address 1). A mask of 0 blocks everything. The low 2 bits of the priority and of the mask are ignored, and the mask reads back with those bits at 0.
- R3: A candidate whose effective priority is 0xFC, the largest level, is never signalled.
- R4: While the active stack is not empty, a candidate is signalled only if (priority AND g) < (running priority AND g). Here g clears the low b+1 bits, with b the selected binary point. With b = 7 no preemption is possible. With an empty stack this test does not apply.
- R5: The request lines are registered and change one clock after their inputs. A Non-secure candidate drives `irq_n` low. A Secure candidate drives `fiq_n` low when control bit 3 is 1, and `irq_n` low otherwise. The two lines are never low together.
- R6: Control bit 0 enables signalling of Secure candidates, and control bit 1 enables signalling of Non-secure candidates.
- R7: Non-secure candidates use the Non-secure binary point (address 3) when control bit 4 is 0, and the Secure binary point (address 2) when it is 1. Secure candidates always use the Secure binary point.
- R8: An acknowledge read of a signalable candidate of matching security returns its ID and pushes its priority, which becomes the running priority. It also raises `ack_vld` for one cycle in the next cycle, with `ack_id` set to the ID.
- R9: A Secure acknowledge read whose candidate is Non-secure returns 1022 and changes nothing when control bit 2 is 0. When control bit 2 is 1, the read acknowledges the candidate as in R8.
- R10: A Non-secure acknowledge read whose candidate is Secure returns 1023 and changes nothing.
- R11: A write to address 5 pops the active stack, which restores the previous running priority. It also pulses `eoi_vld` in the next cycle, with `eoi_id` set to the low 10 bits of the write data. On an empty stack the write has no effect and no pulse.
- R12: A Non-secure write to control copies write bit 0 into control bit 1 and leaves the other control bits unchanged. A Non-secure read of control returns control bit 1 in bit 0. Secure accesses see all 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_vld | input | 1 | Selector presents a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| cand_ns | input | 1 | Candidate is Non-secure |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_ns | input | 1 | Access is Non-secure |
| reg_rdata | output | 32 | Read data, same cycle |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |
| ack_vld | output | 1 | One-cycle acknowledge pulse |
| ack_id | output | 10 | ID acknowledged |
| eoi_vld | output | 1 | One-cycle completion pulse |
| eoi_id | output | 10 | ID reported as completed |

## Verification
The embedded properties check the following on every cycle:
- the two request lines are never low together;
- the fast line is only driven for a Secure candidate;
- a zero mask keeps both lines high in the next cycle;
- an acknowledge pulse never carries a spurious code;
- the stack pointer stays within its depth.

The ordering-dependent behaviours can only be shown by the bench's scenarios. These include preemption against a running priority under different binary points, the swap between binary points under control bit 4, the 1022 and 1023 security mismatches, and stack restoration across nested completions.

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
  parameter int PRIO_BITS   = 6,
  parameter int STACK_DEPTH = 8,
  parameter int ID_W        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cand_vld,
  input  logic [ID_W-1:0] cand_id,
  input  logic [7:0]      cand_prio,
  input  logic            cand_ns,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  input  logic            reg_ns,
  output logic [31:0]     reg_rdata,
  output logic            irq_n,
  output logic            fiq_n,
  output logic            ack_vld,
  output logic [ID_W-1:0] ack_id,
  output logic            eoi_vld,
  output logic [ID_W-1:0] eoi_id
);
  localparam logic [7:0] PMASK = 8'(9'h1FF << (8 - PRIO_BITS));
  localparam int SPW = $clog2(STACK_DEPTH + 1);
  localparam int IW  = $clog2(STACK_DEPTH);
  localparam logic [ID_W-1:0] ID_NS_ONLY = ID_W'(1022);
  localparam logic [ID_W-1:0] ID_NONE    = ID_W'(1023);

  logic [4:0]     ctrl_q;
  logic [7:0]     mask_q;
  logic [2:0]     bps_q, bpns_q;
  logic [7:0]     stk [STACK_DEPTH];
  logic [SPW-1:0] sp_q;

  wire  [7:0] running = (sp_q == '0) ? 8'hFF : stk[IW'(sp_q - SPW'(1))];
  wire  [7:0] cand_p  = cand_prio & PMASK;
  wire  [2:0] bp_sel  = (cand_ns && !ctrl_q[4]) ? bpns_q : bps_q;
  wire  [7:0] gmask   = 8'(9'h1FF << ({1'b0, bp_sel} + 4'd1));
  wire        preempt = (sp_q == '0) || ((cand_p & gmask) < (running & gmask));
  wire        en      = cand_ns ? ctrl_q[1] : ctrl_q[0];
  wire        elig    = cand_vld && en && (cand_p < mask_q) && (cand_p != PMASK)
                        && preempt && (sp_q != SPW'(STACK_DEPTH));
  wire        use_fiq = !cand_ns && ctrl_q[3];

  wire ack_rd     = reg_rd && (reg_addr == 3'd4);
  wire ns_hidden  = !reg_ns && cand_ns && !ctrl_q[2];
  wire sec_hidden = reg_ns && !cand_ns;
  wire take       = ack_rd && elig && !ns_hidden && !sec_hidden;
  wire eoi_wr     = reg_wr && (reg_addr == 3'd5) && (sp_q != '0);

  logic [ID_W-1:0] ack_code;
  always_comb begin
    if (!elig)           ack_code = ID_NONE;
    else if (ns_hidden)  ack_code = ID_NS_ONLY;
    else if (sec_hidden) ack_code = ID_NONE;
    else                 ack_code = cand_id;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = reg_ns ? {31'b0, ctrl_q[1]} : {27'b0, ctrl_q};
      3'd1:    reg_rdata = {24'b0, mask_q};
      3'd2:    reg_rdata = {29'b0, bps_q};
      3'd3:    reg_rdata = {29'b0, bpns_q};
      3'd4:    reg_rdata = 32'(ack_code);
      3'd6:    reg_rdata = {24'b0, running};
      3'd7:    reg_rdata = cand_vld ? 32'(cand_id) : 32'(ID_NONE);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      bps_q   <= '0;
      bpns_q  <= '0;
      sp_q    <= '0;
      irq_n   <= 1'b1;
      fiq_n   <= 1'b1;
      ack_vld <= 1'b0;
      ack_id  <= '0;
      eoi_vld <= 1'b0;
      eoi_id  <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (reg_ns) ctrl_q[1] <= reg_wdata[0];
                else        ctrl_q    <= reg_wdata[4:0];
          3'd1: mask_q <= reg_wdata[7:0] & PMASK;
          3'd2: bps_q  <= reg_wdata[2:0];
          3'd3: bpns_q <= reg_wdata[2:0];
          default: ;
        endcase
      end
      if (take)        sp_q <= sp_q + SPW'(1);
      else if (eoi_wr) sp_q <= sp_q - SPW'(1);
      irq_n   <= !(elig && !use_fiq);
      fiq_n   <= !(elig && use_fiq);
      ack_vld <= take;
      if (take) ack_id <= cand_id;
      eoi_vld <= eoi_wr;
      if (eoi_wr) eoi_id <= reg_wdata[ID_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (take) stk[IW'(sp_q)] <= cand_p;
  end

  // R5
  lines_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!irq_n && !fiq_n));

  // R5
  fiq_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fiq_n) |-> $past(!cand_ns));

  // R2
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |=> (irq_n && fiq_n));

  // R8
  ack_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> (ack_id < ID_NS_ONLY));

  // R11
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(STACK_DEPTH));
endmodule

// File: tb/tb_irq_cpu_if.sv
module tb_irq_cpu_if;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cand_vld = 0, cand_ns = 0;
  logic [9:0] cand_id = 0;
  logic [7:0] cand_prio = 0;
  logic reg_wr = 0, reg_rd = 0, reg_ns = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq_n, fiq_n, ack_vld, eoi_vld;
  logic [9:0] ack_id, eoi_id;

  irq_cpu_if dut (
    .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_id(cand_id),
    .cand_prio(cand_prio), .cand_ns(cand_ns), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ns(reg_ns),
    .reg_rdata(reg_rdata), .irq_n(irq_n), .fiq_n(fiq_n), .ack_vld(ack_vld),
    .ack_id(ack_id), .eoi_vld(eoi_vld), .eoi_id(eoi_id));

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int          ch;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  item_t cur;
  logic [31:0] act;
  int checks = 0, errors = 0;

  task automatic expect_item(int ch, logic [31:0] e, string tag);
    item_t it;
    it.ch = ch; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  always begin
    @(negedge clk);
    #(CLK_P/4);
    while (sbq.size() > 0) begin
      cur = sbq.pop_front();
      case (cur.ch)
        0: act = reg_rdata;
        1: act = 32'(irq_n);
        2: act = 32'(fiq_n);
        3: act = 32'(ack_vld);
        4: act = 32'(ack_id);
        5: act = 32'(eoi_vld);
        default: act = 32'(eoi_id);
      endcase
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s ch%0d actual=%0h expected=%0h", cur.tag, cur.ch, act, cur.exp);
      end
    end
  end

  task automatic wr(int a, logic [31:0] d, bit ns = 0);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = d; reg_ns = ns;
    @(negedge clk);
    reg_wr = 0; reg_ns = 0;
  endtask

  task automatic rd(int a, bit ns, logic [31:0] e, string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = 3'(a); reg_ns = ns;
    expect_item(0, e, tag);
    @(negedge clk);
    reg_rd = 0; reg_ns = 0;
  endtask

  task automatic cand(bit v, int id, int p, bit ns);
    cand_vld = v; cand_id = 10'(id); cand_prio = 8'(p); cand_ns = ns;
  endtask

  task automatic lines(bit irq_e, bit fiq_e, string tag);
    repeat (2) @(negedge clk);
    expect_item(1, 32'(irq_e), tag);
    expect_item(2, 32'(fiq_e), tag);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    lines(1, 1, "R1 lines idle");
    rd(6, 0, 32'hFF, "R1 running reset");
    rd(4, 0, 32'd1023, "R1 ack no candidate");
    expect_item(3, 0, "R1 no ack pulse");

    // R2 mask
    wr(0, 32'h3);
    cand(1, 40, 8'h40, 0);
    lines(1, 1, "R2 mask zero blocks");
    wr(1, 32'h80);
    lines(0, 1, "R2 below mask");
    cand(1, 40, 8'h80, 0);
    lines(1, 1, "R2 equal to mask");
    cand(1, 40, 8'h83, 0);
    lines(1, 1, "R2 low bits ignored");
    cand(1, 40, 8'h7C, 0);
    lines(0, 1, "R2 just below");

    // R3 largest level
    wr(1, 32'hFF);
    rd(1, 0, 32'hFC, "R2 mask readback");
    cand(1, 40, 8'hFC, 0);
    lines(1, 1, "R3 max level masked");
    cand(1, 40, 8'hFE, 0);
    lines(1, 1, "R3 max level low bits");
    cand(1, 40, 8'hF8, 0);
    lines(0, 1, "R3 next level passes");

    // R5 routing
    wr(0, 32'hB);
    cand(1, 40, 8'h40, 0);
    lines(1, 0, "R5 secure to fiq");
    cand(1, 41, 8'h40, 1);
    lines(0, 1, "R5 nonsecure to irq");

    // R6 enables
    wr(0, 32'h2);
    cand(1, 40, 8'h40, 0);
    lines(1, 1, "R6 secure disabled");
    cand(1, 41, 8'h40, 1);
    lines(0, 1, "R6 nonsecure enabled");
    wr(0, 32'h1);
    lines(1, 1, "R6 nonsecure disabled");

    // R8 acknowledge
    wr(0, 32'h3);
    cand(1, 40, 8'h4C, 0);
    rd(4, 0, 32'd40, "R8 ack returns id");
    expect_item(3, 1, "R8 ack pulse");
    expect_item(4, 32'd40, "R8 ack id");
    cand(0, 0, 0, 0);
    rd(6, 0, 32'h4C, "R8 running after ack");

    // R4 preemption against running 0x4C
    cand(1, 41, 8'h4C, 0);
    lines(1, 1, "R4 equal priority");
    cand(1, 41, 8'h48, 0);
    lines(0, 1, "R4 bp0 preempts");
    wr(2, 32'h2);
    lines(1, 1, "R4 bp2 same group");
    cand(1, 41, 8'h44, 0);
    lines(0, 1, "R4 bp2 higher group");
    wr(2, 32'h7);
    lines(1, 1, "R4 bp7 no preemption");
    cand(1, 41, 8'h00, 0);
    lines(1, 1, "R4 bp7 top priority");
    wr(2, 32'h0);

    // R9 secure read of nonsecure winner, ackctl 0
    cand(1, 50, 8'h20, 1);
    rd(4, 0, 32'd1022, "R9 returns 1022");
    expect_item(3, 0, "R9 no ack pulse");
    rd(6, 0, 32'h4C, "R9 running unchanged");

    // R10 nonsecure read of secure winner
    cand(1, 60, 8'h10, 0);
    rd(4, 1, 32'd1023, "R10 returns 1023");
    expect_item(3, 0, "R10 no ack pulse");
    rd(6, 0, 32'h4C, "R10 running unchanged");

    // R9 with ackctl 1
    cand(1, 50, 8'h20, 1);
    wr(0, 32'h7);
    rd(4, 0, 32'd50, "R9 ackctl acknowledges");
    expect_item(3, 1, "R9 ack pulse");
    expect_item(4, 32'd50, "R9 ack id");
    cand(0, 0, 0, 0);
    rd(6, 0, 32'h20, "R9 running after ack");

    // R7 binary point selection for nonsecure
    cand(1, 51, 8'h10, 1);
    lines(0, 1, "R7 nonsecure bp used");
    wr(2, 32'h7);
    lines(0, 1, "R7 secure bp not used");
    wr(0, 32'h17);
    lines(1, 1, "R7 secure bp for both");
    wr(0, 32'h7);
    wr(2, 32'h0);
    cand(0, 0, 0, 0);

    // R11 completion
    wr(5, 32'd50);
    expect_item(5, 1, "R11 eoi pulse");
    expect_item(6, 32'd50, "R11 eoi id");
    rd(6, 0, 32'h4C, "R11 running restored");
    wr(5, 32'd40);
    rd(6, 0, 32'hFF, "R11 stack emptied");
    wr(5, 32'd7);
    expect_item(5, 0, "R11 empty eoi ignored");
    rd(6, 0, 32'hFF, "R11 running stays idle");

    // R12 nonsecure control access
    wr(0, 32'h0, 1);
    rd(0, 0, 32'h5, "R12 ns write touches bit1");
    rd(0, 1, 32'h0, "R12 ns read view");
    wr(0, 32'h1F, 1);
    rd(0, 0, 32'h7, "R12 ns write sets only bit1");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule